// File: doc/BRIEF.md
# Glitch-Free Main Clock Selector with Wake-Up Gate

This block picks the main system clock from several free-running sources. A small select code chooses the source. The code may change while the system runs. The handover disables the old source on one of its own falling edges. The new source is enabled only after the old one is seen to be off. No runt pulse reaches the output during the handover. A reserved code value leaves the active source as it is.

The same block also gates the output clock around sleep. While `sleep_req` is high, the output clock is stopped. When `sleep_req` falls, that is the wake request. Waking from power-down holds the clock off for a fixed number of start-up cycles. These cycles are counted on whichever source is selected, so the delay in time depends on that source. Waking from idle, noise-reduction or standby resumes the clock with no start-up count. The `ready` flag drops only for power-down. It rises on the same edge that releases the clock.

Top module: `wake_clk_mux`

## Requirements
- R1: After reset, source 0 drives `clk_out`. `ready` is high with no start-up count.
- R2: Select code 1 routes source 1 (the slow internal source) to `clk_out`. Select code 2 routes source 2 (the external source).
- R3: Select code 3 is reserved. It leaves the currently active source in place.
- R4: During any switch, no high or low phase of `clk_out` is shorter than the shortest half period of the sources involved. At most one source is enabled at any time.
- R5: After `sleep_req` rises, `clk_out` stops. It stops at the third falling edge of the selected source and shows no rising edge while asleep.
- R6: Sleep mode code 2 is power-down. Entering it drives `ready` low. After `sleep_req` falls, `ready` rises and the clock is released on the 9th falling edge of the selected source: 2 synchronizer stages, 1 decision edge and 6 start-up cycles. The first `clk_out` rising edge follows `ready`.
- R7: The power-down start-up count uses the selected source. The same 9-edge latency holds on the slow source and takes proportionally longer in time.
- R8: Sleep mode codes 0 (idle), 1 (noise-reduction) and 3 (standby) keep `ready` high. They resume `clk_out` at the first rising edge after the 3rd falling edge following the fall of `sleep_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_src | input | N_SRC | Free-running clock sources; bit index equals select code |
| sel | input | SEL_W | Source select code; codes at or above N_SRC are reserved |
| sleep_req | input | 1 | High while asleep; its fall is the wake request |
| sleep_mode | input | 2 | Sleep mode: 0 idle, 1 noise-reduction, 2 power-down, 3 standby |
| clk_out | output | 1 | Gated main clock |
| ready | output | 1 | Main clock stable and running after power-down |

## Verification
The bench measures the output period after each select change. It writes the reserved code while the external source is active. A design that decoded code 3 as a source, or dropped to no source, would show a wrong or missing period. A pulse-width monitor records the narrowest high and low phase across all handovers, which exposes any design that cuts the old clock mid-phase. Wake-up latency is counted in falling edges of the selected source, on both a fast and a slow source. An off-by-one start-up counter, a delay counted on the wrong clock, or a start-up delay wrongly applied to idle or standby each changes the counted edge number.

// File: rtl/wcm_pkg.sv
package wcm_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE  = 2'b00,
      MODE_NOISE = 2'b01,
      MODE_PDOWN = 2'b10,
      MODE_STBY  = 2'b11
   } sleep_mode_e;

   typedef enum logic [1:0] {
      ST_RUN  = 2'b00,
      ST_DOZE = 2'b01,
      ST_WARM = 2'b10
   } gate_state_e;
endpackage

// File: rtl/wcm_lane.sv
module wcm_lane #(
   parameter int N_SRC    = 3,
   parameter int SEL_W    = 2,
   parameter int IDX      = 0,
   parameter int RST_CODE = 0
) (
   input  logic             clk_src,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_code,
   input  logic             others_on,
   output logic             en_o
);
   localparam logic [SEL_W-1:0] MY_CODE  = SEL_W'(IDX);
   localparam logic [SEL_W-1:0] RST_SEL  = SEL_W'(RST_CODE);
   localparam logic             ON_AT_RST = (IDX == RST_CODE);

   logic [SEL_W-1:0] sel_s1, sel_s2;
   logic             oth_s1, oth_s2;
   logic             en_s1, en_q;
   logic             reserved, want;

   assign reserved = int'(sel_s2) >= N_SRC;
   assign want     = (sel_s2 == MY_CODE) | (reserved & en_q);

   always_ff @(negedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         sel_s1 <= RST_SEL;
         sel_s2 <= RST_SEL;
         oth_s1 <= 1'b0;
         oth_s2 <= 1'b0;
         en_s1  <= ON_AT_RST;
         en_q   <= ON_AT_RST;
      end else begin
         sel_s1 <= sel_code;
         sel_s2 <= sel_s1;
         oth_s1 <= others_on;
         oth_s2 <= oth_s1;
         en_s1  <= want & ~oth_s2;
         en_q   <= en_s1;
      end
   end

   assign en_o = en_q;

   // R4
   handoff_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
      $rose(en_q) |-> !others_on);
endmodule

// File: rtl/wcm_wake_gate.sv
module wcm_wake_gate
   import wcm_pkg::*;
#(
   parameter int STARTUP = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic [1:0] sleep_mode,
   output logic       run_o,
   output logic       ready_o
);
   localparam int CNT_W = $clog2(STARTUP + 1);

   gate_state_e       state;
   sleep_mode_e       mode_q;
   logic [CNT_W-1:0]  cnt;
   logic              req_s1, req_s2;
   logic              run_q, ready_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_s1  <= 1'b0;
         req_s2  <= 1'b0;
         state   <= ST_RUN;
         mode_q  <= MODE_IDLE;
         cnt     <= '0;
         run_q   <= 1'b1;
         ready_q <= 1'b1;
      end else begin
         req_s1 <= sleep_req;
         req_s2 <= req_s1;
         unique case (state)
            ST_RUN: if (req_s2) begin
               state  <= ST_DOZE;
               mode_q <= sleep_mode_e'(sleep_mode);
               run_q  <= 1'b0;
               if (sleep_mode_e'(sleep_mode) == MODE_PDOWN) ready_q <= 1'b0;
            end
            ST_DOZE: if (!req_s2) begin
               if (mode_q == MODE_PDOWN) begin
                  state <= ST_WARM;
                  cnt   <= '0;
               end else begin
                  state <= ST_RUN;
                  run_q <= 1'b1;
               end
            end
            ST_WARM: begin
               if (cnt == CNT_W'(STARTUP - 1)) begin
                  state   <= ST_RUN;
                  run_q   <= 1'b1;
                  ready_q <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   assign run_o   = run_q;
   assign ready_o = ready_q;

   // R6
   ready_release_chk: assert property (@(negedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> run_q);
   // R6
   warm_count_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (state == ST_WARM) |-> (int'(cnt) < STARTUP) && !ready_q && !run_q);
   // R5
   doze_gate_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (state == ST_DOZE) |-> !run_q);
   // R8
   light_ready_chk: assert property (@(negedge clk) disable iff (!rst_n)
      !ready_q |-> (mode_q == MODE_PDOWN));
endmodule

// File: rtl/wake_clk_mux.sv
module wake_clk_mux #(
   parameter int N_SRC    = 3,
   parameter int SEL_W    = 2,
   parameter int RST_CODE = 0,
   parameter int STARTUP  = 6
) (
   input  logic             rst_n,
   input  logic [N_SRC-1:0] clk_src,
   input  logic [SEL_W-1:0] sel,
   input  logic             sleep_req,
   input  logic [1:0]       sleep_mode,
   output logic             clk_out,
   output logic             ready
);
   if (N_SRC < 2) begin : g_bad_nsrc
      $error("wake_clk_mux: N_SRC must be at least 2");
   end
   if (N_SRC >= (1 << SEL_W)) begin : g_bad_selw
      $error("wake_clk_mux: SEL_W must leave a reserved code");
   end
   if (RST_CODE >= N_SRC) begin : g_bad_rst
      $error("wake_clk_mux: RST_CODE must name a source");
   end
   if (STARTUP < 1) begin : g_bad_startup
      $error("wake_clk_mux: STARTUP must be at least 1");
   end

   logic [N_SRC-1:0] en_vec;
   logic [N_SRC-1:0] oth_vec;
   logic             clk_mux;
   logic             run;

   for (genvar i = 0; i < N_SRC; i++) begin : g_lane
      assign oth_vec[i] = |(en_vec & ~(N_SRC'(1) << i));
      wcm_lane #(
         .N_SRC(N_SRC), .SEL_W(SEL_W), .IDX(i), .RST_CODE(RST_CODE)
      ) u_lane (
         .clk_src  (clk_src[i]),
         .rst_n    (rst_n),
         .sel_code (sel),
         .others_on(oth_vec[i]),
         .en_o     (en_vec[i])
      );
   end

   assign clk_mux = |(clk_src & en_vec);

   wcm_wake_gate #(.STARTUP(STARTUP)) u_gate (
      .clk       (clk_mux),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .sleep_mode(sleep_mode),
      .run_o     (run),
      .ready_o   (ready)
   );

   assign clk_out = clk_mux & run;

   // R4
   always_comb begin
      if (rst_n) begin
         one_src_chk: assert ($onehot0(en_vec));
      end
   end
endmodule

// File: tb/wake_clk_mux_test.sv
module wake_clk_mux_test;
   logic       clk_fast = 1'b0, clk_slow = 1'b0, clk_ext = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel = 2'd0;
   logic       sleep_req = 1'b0;
   logic [1:0] sleep_mode = 2'd0;
   logic       clk_out, ready;

   always #5  clk_fast = ~clk_fast;
   always #37 clk_slow = ~clk_slow;
   always #13 clk_ext  = ~clk_ext;

   wake_clk_mux uut (
      .rst_n(rst_n), .clk_src({clk_ext, clk_slow, clk_fast}), .sel(sel),
      .sleep_req(sleep_req), .sleep_mode(sleep_mode),
      .clk_out(clk_out), .ready(ready)
   );

   int    n_chk = 0, n_fail = 0;
   int    exp_q[$];
   string tag_q[$];
   int    cur = 0;
   int    negcnt = 0;
   int    pos_out = 0;
   real   min_hi = 1.0e9, min_lo = 1.0e9, t_rise = 0.0, t_fall = 0.0;
   bit    track = 1'b0;

   always @(negedge clk_fast) if (cur == 0) negcnt++;
   always @(negedge clk_slow) if (cur == 1) negcnt++;
   always @(negedge clk_ext)  if (cur == 2) negcnt++;
   always @(posedge clk_out) begin
      pos_out++;
      t_rise = $realtime;
      if (track && t_fall > 0.0 && (t_rise - t_fall) < min_lo) min_lo = t_rise - t_fall;
   end
   always @(negedge clk_out) begin
      t_fall = $realtime;
      if (track && t_rise > 0.0 && (t_fall - t_rise) < min_hi) min_hi = t_fall - t_rise;
   end

   task automatic expect_v(string tag, int v);
      tag_q.push_back(tag);
      exp_q.push_back(v);
   endtask

   task automatic observe(int act);
      string t;
      int    e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      n_chk++;
      if (act != e) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", t, act, e);
      end
   endtask

   task automatic period(output int p);
      realtime t0;
      @(posedge clk_out);
      t0 = $realtime;
      @(posedge clk_out);
      p = int'($realtime - t0);
   endtask

   task automatic select(input logic [1:0] code);
      sel = code;
      if (code != 2'd3) cur = code;
      #3000;
   endtask

   task automatic src_edge();
      if (cur == 0) @(posedge clk_fast);
      else if (cur == 1) @(posedge clk_slow);
      else @(posedge clk_ext);
      #1;
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Enter sleep in a mode, confirm the clock stops, then time the wake-up.
   task automatic sleep_cycle(input logic [1:0] mode, input string tag_stop,
                              input string tag_rdy, input bit pdown);
      int p0, base;
      sleep_mode = mode;
      src_edge();
      sleep_req = 1'b1;
      #400;
      p0 = pos_out;
      #400;
      expect_v({tag_stop, " no clock while asleep"}, 0);
      observe(pos_out - p0);
      expect_v({tag_rdy, " ready while asleep"}, pdown ? 0 : 1);
      observe(int'(ready));
      src_edge();
      base = negcnt;
      sleep_req = 1'b0;
      if (pdown) begin
         @(posedge ready);
         #1;
         expect_v({tag_rdy, " falling edges to ready"}, 9);
         observe(negcnt - base);
      end
      @(posedge clk_out);
      #1;
      expect_v({tag_rdy, " falling edges to first clock"}, pdown ? 9 : 3);
      observe(negcnt - base);
      expect_v({tag_rdy, " ready after wake"}, 1);
      observe(int'(ready));
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int p;
      realtime t0;
      #103;
      expect_v("R1 ready during reset", 1);
      observe(int'(ready));
      rst_n = 1'b1;
      #200;
      expect_v("R1 ready after reset", 1);
      observe(int'(ready));
      period(p);
      expect_v("R1 period after reset", 10);
      observe(p);

      track = 1'b1;
      select(2'd1);
      period(p);
      expect_v("R2 period on code 1", 74);
      observe(p);
      select(2'd2);
      period(p);
      expect_v("R2 period on code 2", 26);
      observe(p);
      select(2'd3);
      period(p);
      expect_v("R3 reserved code keeps source", 26);
      observe(p);
      select(2'd1);
      select(2'd3);
      period(p);
      expect_v("R3 reserved code keeps slow source", 74);
      observe(p);
      select(2'd0);
      period(p);
      expect_v("R2 back to code 0", 10);
      observe(p);
      track = 1'b0;
      expect_v("R4 narrowest high phase >= 5", 1);
      observe(int'(min_hi >= 4.99));
      expect_v("R4 narrowest low phase >= 5", 1);
      observe(int'(min_lo >= 4.99));

      sleep_cycle(2'd0, "R5", "R8 idle", 1'b0);
      select(2'd2);
      sleep_cycle(2'd3, "R5", "R8 standby", 1'b0);
      select(2'd1);
      sleep_cycle(2'd1, "R5", "R8 noise", 1'b0);
      select(2'd0);
      sleep_cycle(2'd2, "R5", "R6 power-down fast", 1'b1);
      select(2'd1);
      t0 = $realtime;
      sleep_cycle(2'd2, "R5", "R7 power-down slow", 1'b1);
      expect_v("R7 slow wake takes longer in time", 1);
      observe(int'(($realtime - t0) > 1400.0));
      period(p);
      expect_v("R7 slow source after wake", 74);
      observe(p);
      summary();
   end
endmodule